// File: doc/BRIEF.md
# Flash Bank Erase Sequencer

This block runs the erase of one flash bank as two consecutive phases. In the first phase it walks every word of the bank, from the bank base to the last address, and asks an external program sequencer to write 0x0000 to each word. It waits for that sequencer's completion and pass/fail result before moving on. In the second phase it applies erase pulses of a fixed length in clock cycles. After each pulse it checks a supply-fail input and then reads the bank back.

The read-back scan keeps its position between pulses. Words that already read as all ones are not read again after a later pulse. The scan resumes at the first word that failed. The number of pulses is bounded by a retry limit that the caller supplies as a precomputed count, and the whole operation ends with an 8-bit result code.

The caller raises `start_i` for one cycle with the bank limits and the retry limit valid. It then waits for the one-cycle `done_o`, whose cycle also carries `code_o`. Checking that the arguments are legal, and timing the program pulse itself, belong to other blocks.

States:
- S_IDLE: waits for start.
- S_PREQ: issues one program request.
- S_PWAIT: waits for the program result.
- S_PULSE: erase pulse active.
- S_SUPPLY: supply check.
- S_RREQ: issues one read.
- S_RCHK: compares the read data.
- S_DONE: reports the result.

Transitions:
- IDLE→PREQ on start.
- PREQ→PWAIT always.
- PWAIT→PREQ on a passed word that is not the last.
- PWAIT→PULSE on a passed last word.
- PWAIT→DONE on a failed word.
- PULSE→SUPPLY when the pulse timer expires.
- SUPPLY→DONE on supply fail.
- SUPPLY→RREQ otherwise.
- RCHK→RREQ on an erased word that is not the last.
- RCHK→DONE on an erased last word.
- RCHK→PULSE on an unerased word with retries left.
- RCHK→DONE on an unerased word with retries spent.
- DONE→IDLE always.

Top module: `flash_bank_eraser`

## Requirements
- R1: After reset and while idle, `prog_req_o`, `erase_pulse_o`, `rd_en_o` and `done_o` are low, and nothing happens until `start_i` is high for a cycle.
- R2: The preprogram phase issues exactly one single-cycle `prog_req_o` per word, with `prog_addr_o` running in ascending order from base to last and `prog_data_o` equal to 0x0000. The next request waits for `prog_done_i`.
- R3: If `prog_done_i` arrives with `prog_ok_i` low, the operation ends with code 0x03, and no erase pulse or read takes place.
- R4: Each erase pulse holds `erase_pulse_o` high for exactly PULSE_CYCLES consecutive cycles. The first pulse starts only after the last word has been preprogrammed.
- R5: `supply_fail_i` is sampled in the cycle after each pulse ends. If it is high, the operation ends with code 0x02 and no read follows.
- R6: The pulse count and scan address are set once, to zero and to the bank base, when the erase phase begins. Each pulse is followed by reads starting at the current scan address. A word read as 0xFFFF advances the address, and an erased last word ends with code 0x00.
- R7: A word that is not 0xFFFF in all 16 bits (for example 0xFFFE or 0x7FFF) triggers another pulse when retries remain. The scan then resumes at that same word, so a bank of N words needing P pulses in total takes N + P - 1 reads.
- R8: When a word is not erased and the number of pulses applied has reached `retry_max_i`, the code is 0x08. A limit of 0 acts as a limit of 1.
- R9: `done_o` is high for exactly one cycle, `code_o` is valid in that cycle, and the block is idle in the next cycle.
- R10: `rd_data_i` is taken one cycle after the cycle in which `rd_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start request |
| base_addr_i | input | ADDR_W | First word address of the bank |
| last_addr_i | input | ADDR_W | Last word address of the bank |
| retry_max_i | input | CNT_W | Maximum number of erase pulses |
| supply_fail_i | input | 1 | Programming supply below threshold |
| prog_req_o | output | 1 | One-cycle request to the program sequencer |
| prog_addr_o | output | ADDR_W | Word address to program |
| prog_data_o | output | DATA_W | Data to program (always zero) |
| prog_done_i | input | 1 | Program sequencer finished |
| prog_ok_i | input | 1 | Program verify passed (valid with done) |
| erase_pulse_o | output | 1 | Erase pulse active |
| rd_en_o | output | 1 | Read strobe |
| rd_addr_o | output | ADDR_W | Read address |
| rd_data_i | input | DATA_W | Read data, one cycle after the strobe |
| done_o | output | 1 | One-cycle completion strobe |
| code_o | output | 8 | Result: 0x00 ok, 0x02 supply, 0x03 preprogram, 0x08 erase |

## Verification
The bench builds the block with ADDR_W=4, CNT_W=8 and PULSE_CYCLES=8. With these values a whole 16-word bank, and runs of up to five pulses, finish in a few hundred cycles, so the retry limit can be reached, a limit of zero can be exercised, and a single-word bank can be covered. A bench model of the flash gives each word the number of pulses it needs before it reads 0xFFFF. Comparing the read count against N + P - 1 separates a resumed scan from one that restarts at the bank base.

// File: rtl/fbe_pkg.sv
package fbe_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_PREQ, S_PWAIT, S_PULSE, S_SUPPLY, S_RREQ, S_RCHK, S_DONE
    } fbe_state_t;

    localparam logic [7:0] CODE_OK       = 8'h00;
    localparam logic [7:0] CODE_SUPPLY   = 8'h02;
    localparam logic [7:0] CODE_PREPROG  = 8'h03;
    localparam logic [7:0] CODE_NOERASE  = 8'h08;
endpackage

// File: rtl/fbe_pulse_timer.sv
module fbe_pulse_timer #(
    parameter int PULSE_CYCLES = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);
    localparam int TW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [TW-1:0] TLAST = TW'(PULSE_CYCLES - 1);

    logic [TW-1:0] tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tick_q <= '0;
        else if (!run_i || last_o)
            tick_q <= '0;
        else
            tick_q <= tick_q + 1'b1;
    end

    assign last_o = run_i && (tick_q == TLAST);

    assert_tick_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q <= TLAST);
endmodule

// File: rtl/fbe_scan_addr.sv
module fbe_scan_addr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              inc_i,
    input  logic [ADDR_W-1:0] last_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              at_last_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_o <= '0;
        else if (load_i)
            addr_o <= load_val_i;
        else if (inc_i)
            addr_o <= addr_o + 1'b1;
    end

    assign at_last_o = (addr_o == last_i);
endmodule

// File: rtl/fbe_retry_count.sv
module fbe_retry_count #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] max_i,
    output logic [CNT_W-1:0] count_o,
    output logic             spent_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count_o <= '0;
        else if (clr_i)
            count_o <= '0;
        else if (inc_i)
            count_o <= count_o + 1'b1;
    end

    assign spent_o = (count_o >= max_i);
endmodule

// File: rtl/flash_bank_eraser.sv
module flash_bank_eraser
    import fbe_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 16,
    parameter int CNT_W        = 24,
    parameter int PULSE_CYCLES = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [ADDR_W-1:0] last_addr_i,
    input  logic [CNT_W-1:0]  retry_max_i,
    input  logic              supply_fail_i,
    output logic              prog_req_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [DATA_W-1:0] prog_data_o,
    input  logic              prog_done_i,
    input  logic              prog_ok_i,
    output logic              erase_pulse_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              done_o,
    output logic [7:0]        code_o
);
    localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

    fbe_state_t state_q, state_d;
    logic [ADDR_W-1:0] base_q, last_q;
    logic [CNT_W-1:0]  max_q;
    logic [7:0]        code_q, code_d;
    logic              code_set;

    logic              walk_load, walk_inc, walk_last;
    logic [ADDR_W-1:0] walk_val, walk_addr;
    logic              rc_clr, rc_inc, rc_spent;
    logic [CNT_W-1:0]  rc_count;
    logic              tmr_run, tmr_last;

    fbe_scan_addr #(.ADDR_W(ADDR_W)) i_walk (
        .clk(clk), .rst_n(rst_n), .load_i(walk_load), .load_val_i(walk_val),
        .inc_i(walk_inc), .last_i(last_q), .addr_o(walk_addr), .at_last_o(walk_last)
    );

    fbe_retry_count #(.CNT_W(CNT_W)) i_retry (
        .clk(clk), .rst_n(rst_n), .clr_i(rc_clr), .inc_i(rc_inc),
        .max_i(max_q), .count_o(rc_count), .spent_o(rc_spent)
    );

    fbe_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) i_timer (
        .clk(clk), .rst_n(rst_n), .run_i(tmr_run), .last_o(tmr_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // captured arguments and result code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            last_q <= '0;
            max_q  <= '0;
            code_q <= CODE_OK;
        end else begin
            if (state_q == S_IDLE && start_i) begin
                base_q <= base_addr_i;
                last_q <= last_addr_i;
                max_q  <= retry_max_i;
            end
            if (code_set)
                code_q <= code_d;
        end
    end

    // next state and datapath strobes
    always_comb begin
        state_d   = state_q;
        walk_load = 1'b0;
        walk_val  = base_q;
        walk_inc  = 1'b0;
        rc_clr    = 1'b0;
        rc_inc    = 1'b0;
        code_set  = 1'b0;
        code_d    = CODE_OK;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    walk_load = 1'b1;
                    walk_val  = base_addr_i;
                    rc_clr    = 1'b1;
                    state_d   = S_PREQ;
                end
            end
            S_PREQ:  state_d = S_PWAIT;
            S_PWAIT: begin
                if (prog_done_i) begin
                    if (!prog_ok_i) begin
                        code_set = 1'b1;
                        code_d   = CODE_PREPROG;
                        state_d  = S_DONE;
                    end else if (walk_last) begin
                        walk_load = 1'b1;
                        rc_clr    = 1'b1;
                        state_d   = S_PULSE;
                    end else begin
                        walk_inc = 1'b1;
                        state_d  = S_PREQ;
                    end
                end
            end
            S_PULSE: begin
                if (tmr_last) begin
                    rc_inc  = 1'b1;
                    state_d = S_SUPPLY;
                end
            end
            S_SUPPLY: begin
                if (supply_fail_i) begin
                    code_set = 1'b1;
                    code_d   = CODE_SUPPLY;
                    state_d  = S_DONE;
                end else begin
                    state_d = S_RREQ;
                end
            end
            S_RREQ: state_d = S_RCHK;
            S_RCHK: begin
                if (rd_data_i == ERASED) begin
                    if (walk_last) begin
                        code_set = 1'b1;
                        code_d   = CODE_OK;
                        state_d  = S_DONE;
                    end else begin
                        walk_inc = 1'b1;
                        state_d  = S_RREQ;
                    end
                end else if (rc_spent) begin
                    code_set = 1'b1;
                    code_d   = CODE_NOERASE;
                    state_d  = S_DONE;
                end else begin
                    state_d = S_PULSE;
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        prog_req_o    = (state_q == S_PREQ);
        erase_pulse_o = (state_q == S_PULSE);
        rd_en_o       = (state_q == S_RREQ);
        done_o        = (state_q == S_DONE);
        tmr_run       = (state_q == S_PULSE);
        prog_addr_o   = walk_addr;
        rd_addr_o     = walk_addr;
        prog_data_o   = '0;
        code_o        = code_q;
    end

    assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req_o, erase_pulse_o, rd_en_o, done_o}));
    assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_o |=> !prog_req_o);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && state_q == S_IDLE));
    assert_supply_after_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_pulse_o) |-> (state_q == S_SUPPLY || state_q == S_DONE));
    assert_nopulse_on_preprog_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && code_o == CODE_PREPROG) |-> (rc_count == '0));
    assert_rd_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && base_q <= last_q) |-> (rd_addr_o >= base_q && rd_addr_o <= last_q));
    assert_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && code_o == CODE_NOERASE) |-> (rc_count >= max_q));
endmodule

// File: tb/test_flash_bank_eraser.sv
`timescale 1ns/100ps
module test_flash_bank_eraser;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int PC = 8;

    typedef struct packed {
        logic [3:0] base;
        logic [3:0] last;
        logic [7:0] rmax;
        logic [3:0] hard;
        logic [3:0] hneed;
        logic [4:0] pfail;
        logic [3:0] sfail;
        logic [7:0] code;
        logic [7:0] pulses;
        logic [7:0] reads;
        logic [7:0] progs;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{4'd4, 4'd11, 8'd5, 4'd6,  4'd3, 5'h00, 4'd0, 8'h00, 8'd3, 8'd10, 8'd8},
        '{4'd4, 4'd11, 8'd2, 4'd6,  4'd3, 5'h00, 4'd0, 8'h08, 8'd2, 8'd4,  8'd8},
        '{4'd4, 4'd11, 8'd5, 4'd6,  4'd1, 5'h17, 4'd0, 8'h03, 8'd0, 8'd0,  8'd4},
        '{4'd4, 4'd11, 8'd5, 4'd6,  4'd3, 5'h00, 4'd2, 8'h02, 8'd2, 8'd3,  8'd8},
        '{4'd9, 4'd9,  8'd3, 4'd9,  4'd1, 5'h00, 4'd0, 8'h00, 8'd1, 8'd1,  8'd1},
        '{4'd4, 4'd11, 8'd4, 4'd11, 4'd4, 5'h00, 4'd0, 8'h00, 8'd4, 8'd11, 8'd8},
        '{4'd4, 4'd5,  8'd4, 4'd4,  4'd5, 5'h00, 4'd0, 8'h08, 8'd4, 8'd4,  8'd2},
        '{4'd0, 4'd15, 8'd0, 4'd0,  4'd1, 5'h00, 4'd0, 8'h00, 8'd1, 8'd16, 8'd16}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] base_addr = '0, last_addr = '0;
    logic [CW-1:0] retry_max = '0;
    logic supply_fail;
    logic prog_req, prog_done, prog_ok;
    logic [AW-1:0] prog_addr, rd_addr;
    logic [DW-1:0] prog_data, rd_data;
    logic erase_pulse, rd_en, done;
    logic [7:0] code;

    int checks = 0;
    int errors = 0;

    // bench flash model state
    vec_t cur = '0;
    int prog_cnt = 0, read_cnt = 0, pulse_cnt = 0;
    int prog_snap = 0, read_snap = 0, pulse_snap = 0;
    int order_err = 0, width_err = 0, zero_err = 0;
    int hi_cnt = 0;
    logic prev_pulse = 1'b0;
    int pend = 0;
    logic [AW-1:0] pend_addr = '0;

    always #2.5 clk = ~clk;

    flash_bank_eraser #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .PULSE_CYCLES(PC)) i_flash_bank_eraser (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base_addr),
        .last_addr_i(last_addr), .retry_max_i(retry_max), .supply_fail_i(supply_fail),
        .prog_req_o(prog_req), .prog_addr_o(prog_addr), .prog_data_o(prog_data),
        .prog_done_i(prog_done), .prog_ok_i(prog_ok), .erase_pulse_o(erase_pulse),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .done_o(done), .code_o(code)
    );

    assign supply_fail = (cur.sfail != 0) && ((pulse_cnt - pulse_snap) == int'(cur.sfail));

    function automatic logic [DW-1:0] word_value(input logic [AW-1:0] a, input int applied);
        int need;
        need = (a == cur.hard) ? int'(cur.hneed) : 1;
        if (applied >= need) return 16'hFFFF;
        return a[0] ? 16'h7FFF : 16'hFFFE;
    endfunction

    // program sequencer model: done two cycles after a request (R2, R3)
    always @(posedge clk) begin
        prog_done <= 1'b0;
        if (prog_req) begin
            if (prog_addr != cur.base + AW'(prog_cnt - prog_snap)) order_err <= order_err + 1;
            if (prog_data != '0) zero_err <= zero_err + 1;
            prog_cnt  <= prog_cnt + 1;
            pend      <= 2;
            pend_addr <= prog_addr;
        end else if (pend == 1) begin
            pend      <= 0;
            prog_done <= 1'b1;
            prog_ok   <= !(cur.pfail[4] && pend_addr == cur.pfail[3:0]);
        end else if (pend > 1) begin
            pend <= pend - 1;
        end
    end

    // read model: data one cycle after strobe (R10)
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data  <= word_value(rd_addr, pulse_cnt - pulse_snap);
            read_cnt <= read_cnt + 1;
        end
    end

    // pulse monitor (R4)
    always @(posedge clk) begin
        prev_pulse <= erase_pulse;
        if (erase_pulse) begin
            hi_cnt <= prev_pulse ? hi_cnt + 1 : 1;
            if (!prev_pulse) pulse_cnt <= pulse_cnt + 1;
        end else if (prev_pulse) begin
            if (hi_cnt != PC) width_err <= width_err + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int cyc;
        int ow, ww;
        @(negedge clk);
        cur = v;
        prog_snap = prog_cnt; read_snap = read_cnt; pulse_snap = pulse_cnt;
        ow = order_err; ww = width_err;
        base_addr = v.base; last_addr = v.last; retry_max = v.rmax;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        $display("vector %0d", idx);
        chk("R9 done seen", int'(done), 1);
        chk("R3/R5/R6/R8 code", int'(code), int'(v.code));
        @(negedge clk);
        chk("R9 done one cycle", int'(done), 0);
        chk("R4 pulse count", pulse_cnt - pulse_snap, int'(v.pulses));
        chk("R7 read count", read_cnt - read_snap, int'(v.reads));
        chk("R2 program count", prog_cnt - prog_snap, int'(v.progs));
        chk("R2 program order", order_err - ow, 0);
        chk("R4 pulse width", width_err - ww, 0);
    endtask

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        chk("R1 reset done", int'(done), 0);
        chk("R1 reset pulse", int'(erase_pulse), 0);
        chk("R1 reset prog_req", int'(prog_req), 0);
        chk("R1 reset rd_en", int'(rd_en), 0);
        rst_n = 1'b1;
        // R1: no activity without start
        c0 = prog_cnt;
        repeat (20) @(negedge clk);
        chk("R1 idle without start", prog_cnt - c0 + int'(erase_pulse) + int'(rd_en), 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // directed: back-to-back start right after done, resume vs restart (R6, R7)
        run_vec('{4'd2, 4'd7, 8'd6, 4'd7, 4'd5, 5'h00, 4'd0, 8'h00, 8'd5, 8'd10, 8'd6}, 100);
        // directed: supply fail on first pulse gives no read (R5)
        run_vec('{4'd0, 4'd3, 8'd3, 4'd0, 4'd1, 5'h00, 4'd1, 8'h02, 8'd1, 8'd0, 8'd4}, 101);
        // directed: preprogram fails on the very first word (R3)
        run_vec('{4'd3, 4'd8, 8'd3, 4'd0, 4'd1, 5'h13, 4'd0, 8'h03, 8'd0, 8'd0, 8'd1}, 102);
        chk("R2 program data zero", zero_err, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule